// File: doc/BRIEF.md
# ISA-Style IO Bus Access Sequencer

This block turns single read and write requests from an on-chip memory-mapped host port into timed strobe cycles on an external 16-bit IO bus. The target is an off-chip Ethernet controller that runs in IO mode. The host presents a word address, active-high byte enables and write data, then waits while `wait_o` is high. Read data comes back with a one-cycle valid pulse.

The device side has no chip-select. The device only responds while its active-low read or write strobe is low. The sequencer therefore frames every access in a fixed window: setup clocks with no strobe, then wait-state clocks with one strobe low, then hold clocks after the strobe rises. Address, byte enables and write data stay steady across the whole window.

The shared data bus is split into an output, an output enable and an input. The tristate pad in the pad ring joins them onto the bidirectional pins. The device interrupt is passed straight to the host. The device reset output is the inverse of the system reset.

Top module: `isa_io_seq`

## Requirements
- R1: While `rst_ni` is low and at the first clock after its release, both strobes are high, `dev_data_oe_o` is 0, `wait_o` is 0 and `rvalid_o` is 0. `dev_rst_o` equals the inverse of `rst_ni`.
- R2: A request (`req_i` high) is accepted only at a clock edge where `wait_o` is low. `wait_o` is high from the cycle after acceptance until the last hold cycle has ended, and is low again in the following cycle.
- R3: The first SETUP_CYC cycles (default 1) after acceptance keep both strobes high, while `dev_addr_o`, `dev_be_no` and, for writes, `dev_data_o` already show the request.
- R4: After setup, exactly one strobe is low for exactly WAIT_CYC consecutive cycles (default 5). `dev_ior_no` is used for reads (`we_i`=0) and `dev_iow_no` for writes (`we_i`=1). The two strobes are never low together.
- R5: For HOLD_CYC cycles (default 1) after the strobe rises, `dev_addr_o`, `dev_be_no` and write data stay unchanged while both strobes are high.
- R6: For a read, `dev_data_i` is captured on the clock edge that ends the last wait-state cycle, while the read strobe is still low. It appears on `rdata_o` with `rvalid_o` high for exactly the first hold cycle.
- R7: `dev_data_oe_o` is high exactly from the first setup cycle through the last hold cycle of a write, and is low at all other times.
- R8: `dev_be_no` is the bitwise inverse of the accepted `be_i`. Bit 1 of `dev_be_no` drives the device high-byte enable pin.
- R9: A request raised while `wait_o` is high is ignored. It causes no strobe and does not change `dev_addr_o`, either during the running access or after it.
- R10: `irq_o` follows `dev_irq_i` with no delay. It is 0 whenever the device interrupt is idle (low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host word address |
| be_i | input | DATA_W/8 | Active-high byte enables |
| wdata_i | input | DATA_W | Write data |
| wait_o | output | 1 | Host waitrequest, high while an access runs |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | One-cycle read-data valid pulse |
| irq_o | output | 1 | Interrupt to host |
| dev_addr_o | output | ADDR_W | Device register address |
| dev_be_no | output | DATA_W/8 | Active-low byte enables, bit 1 = high-byte enable |
| dev_data_o | output | DATA_W | Data driven to the bus pad |
| dev_data_i | input | DATA_W | Data read from the bus pad |
| dev_data_oe_o | output | 1 | Bus pad output enable |
| dev_ior_no | output | 1 | Active-low read strobe |
| dev_iow_no | output | 1 | Active-low write strobe |
| dev_irq_i | input | 1 | Device interrupt request |
| dev_rst_o | output | 1 | Active-high device reset |

## Verification
The bench builds the block with its defaults: a 3-bit address, a 16-bit bus and 1/5/1 setup, wait and hold cycles. This small space lets it sweep every address against every byte-enable pattern in both directions. Each access is followed cycle by cycle, so every phase boundary, the read capture edge and the output-enable window are each checked for all 64 combinations. A device model in the bench returns data only while the read strobe is low and latches written data on the rising write strobe. A request injected mid-access and an interrupt toggle cover the remaining cases.

// File: rtl/isa_io_seq_pkg.sv
package isa_io_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/isa_io_seq_timer.sv
module isa_io_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/isa_io_seq_fsm.sv
module isa_io_seq_fsm
  import isa_io_seq_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WAIT_CYC  = 5,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  output logic accept_o,
  output logic sample_o,
  output logic busy_o,
  output logic oe_o,
  output logic ior_no,
  output logic iow_no
);
  localparam int MAX_LEN = max3(SETUP_CYC, WAIT_CYC, HOLD_CYC);
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  phase_e           state_q, state_d;
  logic             we_q, we_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;
  logic             ior_q, iow_q, oe_q;

  isa_io_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  assign accept_o = (state_q == PH_IDLE) && req_i;
  assign we_d     = accept_o ? we_i : we_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      PH_IDLE: if (req_i) begin
        state_d  = PH_SETUP;
        load     = 1'b1;
        load_val = CNT_W'(SETUP_CYC - 1);
      end
      PH_SETUP: if (last) begin
        state_d  = PH_STROBE;
        load     = 1'b1;
        load_val = CNT_W'(WAIT_CYC - 1);
      end
      PH_STROBE: if (last) begin
        state_d  = PH_HOLD;
        load     = 1'b1;
        load_val = CNT_W'(HOLD_CYC - 1);
      end
      PH_HOLD: if (last) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  // strobes and enable are registered from next state: clean pin edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      we_q    <= 1'b0;
      ior_q   <= 1'b1;
      iow_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      ior_q   <= !((state_d == PH_STROBE) && !we_d);
      iow_q   <= !((state_d == PH_STROBE) && we_d);
      oe_q    <= (state_d != PH_IDLE) && we_d;
    end
  end

  assign sample_o = (state_q == PH_STROBE) && last && !we_q;
  assign busy_o   = (state_q != PH_IDLE);
  assign oe_o     = oe_q;
  assign ior_no   = ior_q;
  assign iow_no   = iow_q;
endmodule

// File: rtl/isa_io_seq_datapath.sv
module isa_io_seq_datapath #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic                sample_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   bus_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W/8-1:0] be_no,
  output logic [DATA_W-1:0]   bus_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o
);
  localparam int BE_W = DATA_W / 8;

  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      be_q    <= be_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample_i;
      if (sample_i) rdata_q <= bus_i;
    end
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign be_no[g] = ~be_q[g];
  end

  assign addr_o   = addr_q;
  assign bus_o    = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WAIT_CYC  = 5,
  parameter int HOLD_CYC  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                wait_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic                irq_o,
  output logic [ADDR_W-1:0]   dev_addr_o,
  output logic [DATA_W/8-1:0] dev_be_no,
  output logic [DATA_W-1:0]   dev_data_o,
  input  logic [DATA_W-1:0]   dev_data_i,
  output logic                dev_data_oe_o,
  output logic                dev_ior_no,
  output logic                dev_iow_no,
  input  logic                dev_irq_i,
  output logic                dev_rst_o
);
  logic accept, sample;

  isa_io_seq_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .WAIT_CYC  (WAIT_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .accept_o (accept),
    .sample_o (sample),
    .busy_o   (wait_o),
    .oe_o     (dev_data_oe_o),
    .ior_no   (dev_ior_no),
    .iow_no   (dev_iow_no)
  );

  isa_io_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .sample_i (sample),
    .addr_i   (addr_i),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .bus_i    (dev_data_i),
    .addr_o   (dev_addr_o),
    .be_no    (dev_be_no),
    .bus_o    (dev_data_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign irq_o     = dev_irq_i;
  assign dev_rst_o = ~rst_ni;
endmodule

// File: rtl/isa_io_seq_chk.sv
module isa_io_seq_chk #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wait_o,
  input logic                rvalid_o,
  input logic [ADDR_W-1:0]   dev_addr_o,
  input logic [DATA_W/8-1:0] dev_be_no,
  input logic [DATA_W-1:0]   dev_data_o,
  input logic                dev_data_oe_o,
  input logic                dev_ior_no,
  input logic                dev_iow_no
);
  localparam int LEN_W = $clog2(WAIT_CYC + 2);

  logic             strobe;
  logic [LEN_W-1:0] low_len_q;

  assign strobe = !dev_ior_no || !dev_iow_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_len_q <= '0;
    else if (strobe) low_len_q <= (low_len_q == '1) ? low_len_q : low_len_q + 1'b1;
    else low_len_q <= '0;
  end

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dev_ior_no && !dev_iow_no));

  assert_strobe_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(!strobe) |-> (low_len_q == LEN_W'(WAIT_CYC)));

  assert_strobe_in_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> wait_o);

  assert_setup_before_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe) |-> $past(wait_o));

  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(!strobe) |-> ($stable(dev_addr_o) && $stable(dev_be_no) && $stable(dev_data_o)));

  assert_rvalid_after_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(!dev_ior_no) && dev_ior_no));

  assert_oe_in_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_data_oe_o |-> wait_o);

  assert_oe_not_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_ior_no |-> !dev_data_oe_o);
endmodule

bind isa_io_seq isa_io_seq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WAIT_CYC (WAIT_CYC)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wait_o        (wait_o),
  .rvalid_o      (rvalid_o),
  .dev_addr_o    (dev_addr_o),
  .dev_be_no     (dev_be_no),
  .dev_data_o    (dev_data_o),
  .dev_data_oe_o (dev_data_oe_o),
  .dev_ior_no    (dev_ior_no),
  .dev_iow_no    (dev_iow_no)
);

// File: tb/test_isa_io_seq.sv
`timescale 1ns/1ps
module test_isa_io_seq;
  localparam int AW = 3, DW = 16, BW = DW / 8;
  localparam int SU = 1, WS = 5, HD = 1;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [BW-1:0] be_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          wait_o, rvalid_o, irq_o;
  logic [DW-1:0] rdata_o, dev_data_o, dev_data_i;
  logic [AW-1:0] dev_addr_o;
  logic [BW-1:0] dev_be_no;
  logic          dev_data_oe_o, dev_ior_no, dev_iow_no, dev_rst_o;
  logic          dev_irq_i = 1'b0;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  isa_io_seq #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .WAIT_CYC(WS), .HOLD_CYC(HD)) i_isa_io_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .wait_o(wait_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .irq_o(irq_o), .dev_addr_o(dev_addr_o), .dev_be_no(dev_be_no),
    .dev_data_o(dev_data_o), .dev_data_i(dev_data_i), .dev_data_oe_o(dev_data_oe_o),
    .dev_ior_no(dev_ior_no), .dev_iow_no(dev_iow_no), .dev_irq_i(dev_irq_i),
    .dev_rst_o(dev_rst_o)
  );

  function automatic logic [DW-1:0] dev_word(logic [AW-1:0] a);
    return 16'h5A3C ^ (16'(a) * 16'h0101) ^ {16'(a) << 13};
  endfunction

  // device model: drives only while read strobe low, latches on write strobe rise
  assign dev_data_i = !dev_ior_no ? dev_word(dev_addr_o) : 16'hDEAD;
  logic [DW-1:0] wr_seen;
  logic [AW-1:0] wr_addr_seen;
  int            wr_count = 0;
  always @(posedge dev_iow_no) if (rst_ni) begin
    wr_seen      <= dev_data_o;
    wr_addr_seen <= dev_addr_o;
    wr_count     <= wr_count + 1;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [BW-1:0] b, input logic [DW-1:0] d);
    bit ok;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; be_i = b; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; addr_i = ~a; wdata_i = ~d;
    // setup
    chk(dev_ior_no && dev_iow_no && wait_o, "R3 setup strobes", {dev_ior_no, dev_iow_no, wait_o}, 3'b111);
    chk(dev_addr_o == a, "R3 setup addr", 32'(dev_addr_o), 32'(a));
    chk(dev_be_no == ~b, "R8 be mapping", 32'(dev_be_no), 32'(~b));
    chk(dev_data_oe_o == w, "R7 oe setup", 32'(dev_data_oe_o), 32'(w));
    if (w) chk(dev_data_o == d, "R3 setup wdata", 32'(dev_data_o), 32'(d));
    // wait states
    ok = 1'b1;
    for (int i = 0; i < WS; i++) begin
      @(negedge clk_i);
      if (w ? (dev_iow_no || !dev_ior_no) : (dev_ior_no || !dev_iow_no)) ok = 1'b0;
      if (!wait_o || dev_addr_o != a || dev_data_oe_o != w) ok = 1'b0;
    end
    chk(ok, "R4 strobe window", {dev_ior_no, dev_iow_no}, w ? 2'b10 : 2'b01);
    // hold
    @(negedge clk_i);
    chk(dev_ior_no && dev_iow_no && wait_o && dev_addr_o == a && dev_be_no == ~b,
        "R5 hold", {dev_ior_no, dev_iow_no, wait_o}, 3'b111);
    if (w) chk(dev_data_oe_o && dev_data_o == d, "R5 R7 hold wdata", 32'(dev_data_o), 32'(d));
    chk(rvalid_o == !w, "R6 rvalid pulse", 32'(rvalid_o), 32'(!w));
    if (!w) chk(rdata_o == dev_word(a), "R6 rdata", 32'(rdata_o), 32'(dev_word(a)));
    // back to idle
    @(negedge clk_i);
    chk(!wait_o && !dev_data_oe_o && !rvalid_o, "R2 R7 idle", {wait_o, dev_data_oe_o, rvalid_o}, 3'b000);
    if (w) chk(wr_seen == d && wr_addr_seen == a, "R4 write latched", 32'(wr_seen), 32'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int wc;
    repeat (3) @(negedge clk_i);
    chk(dev_ior_no && dev_iow_no && !dev_data_oe_o && !wait_o && !rvalid_o,
        "R1 reset outputs", {dev_ior_no, dev_iow_no, dev_data_oe_o, wait_o, rvalid_o}, 5'b11000);
    chk(dev_rst_o == 1'b1, "R1 device reset asserted", 32'(dev_rst_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dev_rst_o == 1'b0 && dev_ior_no && dev_iow_no && !wait_o, "R1 after release",
        {dev_rst_o, wait_o}, 2'b00);

    // exhaustive sweep: address x byte enables x direction
    for (int a = 0; a < (1 << AW); a++)
      for (int b = 0; b < (1 << BW); b++)
        for (int w = 0; w < 2; w++)
          access(w[0], AW'(a), BW'(b), DW'(a * 16'h1357 ^ (b << 8) ^ (w * 16'h8001)));

    // request while busy is ignored (R9)
    wc = wr_count;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 3'd2; be_i = 2'b11;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 3'd5;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(dev_addr_o == 3'd2 && !dev_ior_no && dev_iow_no, "R9 busy request no effect",
        32'(dev_addr_o), 32'd2);
    repeat (WS + HD + 4) @(negedge clk_i);
    chk(!wait_o && dev_iow_no && dev_ior_no && dev_addr_o == 3'd2 && wr_count == wc,
        "R9 busy request dropped", 32'(dev_addr_o), 32'd2);

    // back-to-back with req held high: re-accepted only after idle (R2)
    req_i = 1'b1; we_i = 1'b0; addr_i = 3'd7;
    @(negedge clk_i);
    chk(wait_o, "R2 accepted", 32'(wait_o), 1);
    repeat (SU + WS + HD - 1) @(negedge clk_i);
    chk(wait_o, "R2 wait through hold", 32'(wait_o), 1);
    @(negedge clk_i);
    chk(!wait_o, "R2 idle gap between requests", 32'(wait_o), 0);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(wait_o, "R2 second acceptance", 32'(wait_o), 1);
    repeat (SU + WS + HD + 2) @(negedge clk_i);

    // interrupt passthrough (R10)
    chk(irq_o == 1'b0, "R10 irq idle", 32'(irq_o), 0);
    dev_irq_i = 1'b1; #1;
    chk(irq_o == 1'b1, "R10 irq high", 32'(irq_o), 1);
    dev_irq_i = 1'b0; #1;
    chk(irq_o == 1'b0, "R10 irq low", 32'(irq_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule